// File: doc/BRIEF.md
# Split-Byte Sample Output Formatter

This block takes 14-bit converted samples, one per conversion slot, and presents each one on an 8-bit output bus as two bytes: the upper part first, then the lower part. The block runs on a byte clock, and one conversion slot spans two byte-clock cycles. The first cycle of a slot is the high-byte half and the second is the low-byte half. A fixed three-slot delay line separates sample capture from output. The sample's channel tag and valid flag travel through that delay line with the data.

The high byte carries sample bits 13..6. The low byte carries sample bits 5..0, left-aligned in bus bits 7..2, with bus bits 1..0 driven as zero. An active-low output enable controls the bus. While the enable is high the bus floats and a drive flag reports that it is released. The delay line keeps advancing while the bus is released.

Upstream logic holds a sample, its valid flag and its tag steady for the whole of a slot. The sample is captured at the rising clock edge that closes the slot, which is the edge ending the low-byte half.

Top module: `byte_split_fmt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hi_byte` is 1, `data_ok` is 0, `tag_q` is 0, and with `oe_n` low the bus carries 8'h00.
- R2: `hi_byte` is 1 in the first cycle of each two-cycle slot and 0 in the second. It alternates every cycle, starting with 1 in the first cycle after reset.
- R3: While `hi_byte` is 1 and the bus is enabled, bus bits 7..0 equal bits 13..6 of the delayed sample.
- R4: While `hi_byte` is 0 and the bus is enabled, bus bits 7..2 equal bits 5..0 of the delayed sample, and bus bits 1..0 are 0.
- R5: A sample presented during slot n appears on the bus during slot n+3, which is exactly three slots of latency.
- R6: `tag_q` during slot n+3 equals the tag presented with the sample in slot n, and it holds the same value in both halves of the slot.
- R7: During slot n+3, `data_ok` equals the valid flag presented in slot n. It is therefore 0 during the first three slots after reset.
- R8: While `oe_n` is 1, the bus is high-impedance and `bus_drive` is 0. The delay line keeps advancing, so samples taken during that time appear correctly once the bus is enabled again.
- R9: A slot with the valid flag low still occupies one delay stage. It yields one slot with `data_ok` low and leaves the alignment of later samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock; two cycles per conversion slot |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_data | input | 14 | Converted sample, held for a whole slot |
| smp_vld | input | 1 | Sample valid flag, held for a whole slot |
| smp_tag | input | 2 | Channel tag of the sample |
| oe_n | input | 1 | Output enable, active low |
| bus_q | output | 8 | Byte output bus; high-impedance while oe_n is 1 |
| bus_drive | output | 1 | 1 while the bus is driven |
| hi_byte | output | 1 | 1 during the high-byte half of a slot |
| tag_q | output | 2 | Channel tag of the byte on the bus |
| data_ok | output | 1 | Delayed valid flag of the sample on the bus |

## Verification
The hardest case to reach from the ports is showing that the pipeline stays aligned while the bus is released. When the bus is released it gives no view of the data, so a fault in the delay line could go unseen.

The stimulus releases the bus for several slots while distinct samples keep entering. It then re-enables the bus and checks that the samples from the released slots come out in order, exactly three slots after entry.

A second hard case is a gap of invalid slots between valid ones. The bench interleaves invalid slots with valid ones and checks that each valid sample still lands three slots later, with `data_ok` low only in the gap slots.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  // Half of a conversion slot: the high byte goes out first.
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } slot_half_e;

  function automatic logic is_high_half(slot_half_e h);
    return h == PH_HI;
  endfunction
endpackage

// File: rtl/fmt_slot_phase.sv
module fmt_slot_phase
  import fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output slot_half_e half,
  output logic       slot_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= PH_HI;
    else        half <= (half == PH_HI) ? PH_LO : PH_HI;
  end

  // The slot closes on the edge that ends the low-byte half.
  assign slot_end = (half == PH_LO);

  // R2: the two halves alternate every cycle.
  a_r2_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (half == PH_HI) |=> (half == PH_LO));
  a_r2_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (half == PH_LO) |=> (half == PH_HI));
endmodule

// File: rtl/fmt_delay_line.sv
module fmt_delay_line #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_vld,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_vld
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DATA_W-1:0] d_q [DEPTH];
  logic [TAG_W-1:0]  t_q [DEPTH];
  logic [DEPTH-1:0]  v_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [DATA_W-1:0] d_src;
    logic [TAG_W-1:0]  t_src;
    logic              v_src;
    if (g == 0) begin : g_head
      assign d_src = in_data;
      assign t_src = in_tag;
      assign v_src = in_vld;
    end else begin : g_body
      assign d_src = d_q[g-1];
      assign t_src = t_q[g-1];
      assign v_src = v_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[g] <= '0;
        t_q[g] <= '0;
        v_q[g] <= 1'b0;
      end else if (adv) begin
        d_q[g] <= d_src;
        t_q[g] <= t_src;
        v_q[g] <= v_src;
      end
    end
  end

  assign out_data = d_q[LAST];
  assign out_tag  = t_q[LAST];
  assign out_vld  = v_q[LAST];

  // R5: the output stage only changes on an advance, taking the stage before it.
  a_r5_hold_between_advances: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_data));
  if (DEPTH > 1) begin : g_chk
    a_r5_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (out_data == $past(d_q[LAST-1])));
    a_r7_valid_advance: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (out_vld == $past(v_q[LAST-1])));
  end
endmodule

// File: rtl/fmt_byte_mux.sv
module fmt_byte_mux
  import fmt_pkg::*;
#(
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned BYTE_W = 8
) (
  input  slot_half_e        half,
  input  logic [SAMP_W-1:0] sample,
  output logic [BYTE_W-1:0] word
);
  localparam int unsigned LO_W  = SAMP_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - LO_W;

  // Upper bits of the sample, filling the whole byte.
  function automatic logic [BYTE_W-1:0] upper_part(logic [SAMP_W-1:0] s);
    return s[SAMP_W-1 -: BYTE_W];
  endfunction

  // Remaining bits, left-aligned, padded with zeros below.
  function automatic logic [BYTE_W-1:0] lower_part(logic [SAMP_W-1:0] s);
    return {s[LO_W-1:0], {PAD_W{1'b0}}};
  endfunction

  assign word = is_high_half(half) ? upper_part(sample) : lower_part(sample);
endmodule

// File: rtl/byte_split_fmt.sv
module byte_split_fmt
  import fmt_pkg::*;
#(
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned TAG_W  = 2,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SAMP_W-1:0] smp_data,
  input  logic              smp_vld,
  input  logic [TAG_W-1:0]  smp_tag,
  input  logic              oe_n,
  output logic [BYTE_W-1:0] bus_q,
  output logic              bus_drive,
  output logic              hi_byte,
  output logic [TAG_W-1:0]  tag_q,
  output logic              data_ok
);
  localparam int unsigned LO_W  = SAMP_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - LO_W;

  slot_half_e        half;
  logic              slot_end;
  logic [SAMP_W-1:0] pipe_data;
  logic [BYTE_W-1:0] bus_word;

  fmt_slot_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .half     (half),
    .slot_end (slot_end)
  );

  fmt_delay_line #(
    .DATA_W (SAMP_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (slot_end),
    .in_data  (smp_data),
    .in_tag   (smp_tag),
    .in_vld   (smp_vld),
    .out_data (pipe_data),
    .out_tag  (tag_q),
    .out_vld  (data_ok)
  );

  fmt_byte_mux #(
    .SAMP_W (SAMP_W),
    .BYTE_W (BYTE_W)
  ) u_mux (
    .half   (half),
    .sample (pipe_data),
    .word   (bus_word)
  );

  assign hi_byte   = is_high_half(half);
  assign bus_drive = !oe_n;
  assign bus_q     = bus_drive ? bus_word : {BYTE_W{1'bz}};

  // R3/R4: the two bytes of a slot rebuild the delayed sample.
  a_r3_bytes_rebuild_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (half == PH_LO) |-> ({$past(bus_word), bus_word[BYTE_W-1 -: LO_W]} == pipe_data));
  // R4: padding bits of the low byte are zero.
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (half == PH_LO) |-> (bus_word[PAD_W-1:0] == '0));
  // R6: the tag holds across both halves of a slot.
  a_r6_tag_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (half == PH_LO) |-> $stable(tag_q));
  // R7: valid output only changes at the start of a slot.
  a_r7_ok_changes_at_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(data_ok) |-> (half == PH_HI));
endmodule

// File: tb/test_byte_split_fmt.sv
`timescale 1ns/1ps
module test_byte_split_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] smp_data = '0;
  logic        smp_vld = 1'b0;
  logic [1:0]  smp_tag = '0;
  logic        oe_n = 1'b0;
  wire  [7:0]  bus_q;
  logic        bus_drive, hi_byte, data_ok;
  logic [1:0]  tag_q;

  int checks = 0;
  int fails  = 0;
  int sl     = 0;
  bit done   = 1'b0;

  logic [13:0] h_d [0:255];
  logic        h_v [0:255];
  logic [1:0]  h_t [0:255];

  always #10 clk = ~clk;

  byte_split_fmt i_byte_split_fmt (
    .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_vld(smp_vld),
    .smp_tag(smp_tag), .oe_n(oe_n), .bus_q(bus_q), .bus_drive(bus_drive),
    .hi_byte(hi_byte), .tag_q(tag_q), .data_ok(data_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s slot %0d: actual %0h expected %0h", req, sl, act, exp);
    end
  endtask

  // One slot: present inputs, check both halves against the sample from three slots back.
  task automatic run_slot(input logic [13:0] d, input logic v, input logic [1:0] t, input logic oe);
    logic [13:0] ed;
    logic        ev;
    logic [1:0]  et;
    smp_data = d; smp_vld = v; smp_tag = t; oe_n = oe;
    h_d[sl] = d; h_v[sl] = v; h_t[sl] = t;
    ed = (sl >= 3) ? h_d[sl-3] : 14'h0;
    ev = (sl >= 3) ? h_v[sl-3] : 1'b0;
    et = (sl >= 3) ? h_t[sl-3] : 2'h0;
    #1;
    chk(hi_byte == 1'b1, "R2 high half flag", hi_byte, 1);
    chk(data_ok == ev, "R7 R9 data_ok", data_ok, ev);
    chk(bus_drive == !oe, "R8 drive flag", bus_drive, !oe);
    if (ev) chk(tag_q == et, "R6 tag high half", tag_q, et);
    if (ev && !oe) chk(bus_q == ed[13:6], "R3 R5 high byte", bus_q, ed[13:6]);
    @(negedge clk); #1;
    chk(hi_byte == 1'b0, "R2 low half flag", hi_byte, 0);
    if (ev) chk(tag_q == et, "R6 tag low half", tag_q, et);
    if (ev && !oe) chk(bus_q == {ed[5:0], 2'b00}, "R4 R5 low byte", bus_q, {ed[5:0], 2'b00});
    @(negedge clk);
    sl++;
  endtask

  task automatic t_reset();
    #1;
    chk(hi_byte == 1'b1 && data_ok == 1'b0 && tag_q == 2'd0, "R1 reset outputs",
        {hi_byte, data_ok, tag_q}, 4'b1000);
    chk(bus_q == 8'h00, "R1 reset bus", bus_q, 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk(hi_byte == 1'b1 && data_ok == 1'b0, "R1 first cycle after reset", {hi_byte, data_ok}, 2'b10);
  endtask

  task automatic t_stream();
    run_slot(14'h3FFF, 1'b1, 2'd1, 1'b0);
    run_slot(14'h0000, 1'b1, 2'd2, 1'b0);
    run_slot(14'h2AAA, 1'b1, 2'd3, 1'b0);
    run_slot(14'h1555, 1'b1, 2'd0, 1'b0);
    for (int k = 0; k < 8; k++)
      run_slot(14'(k * 14'h0813 + 14'h0041), 1'b1, 2'(k), 1'b0);
  endtask

  task automatic t_gap();
    run_slot(14'h0ABC, 1'b0, 2'd2, 1'b0);
    run_slot(14'h1234, 1'b1, 2'd1, 1'b0);
    run_slot(14'h3210, 1'b0, 2'd3, 1'b0);
    run_slot(14'h0F0F, 1'b0, 2'd0, 1'b0);
    run_slot(14'h30C3, 1'b1, 2'd2, 1'b0);
    for (int k = 0; k < 4; k++) run_slot(14'h0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_release();
    for (int k = 0; k < 5; k++)
      run_slot(14'(14'h0101 * (k + 3)), 1'b1, 2'(k + 1), 1'b1);
    for (int k = 0; k < 5; k++)
      run_slot(14'(14'h2003 + k), 1'b1, 2'(k), 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_stream();
    t_gap();
    t_release();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule